// File: doc/BRIEF.md
# Transmit Time-Out Timer

This block puts a ceiling on how long a single transmission can last. A small configuration code picks the limit. Each bit of the code stands for a fixed number of seconds, and the limit is the sum of the bits that are set. The limit is captured when push-to-talk goes high. From then on, a one-second tick counts it down. When the limit runs out, transmit is forced off and an expired flag is raised. Both stay that way until push-to-talk is let go. The next press starts a fresh, full time-out.

A parameter selects one of two code layouts. The 3-bit layout reserves its all-ones code to inhibit transmit on the channel entirely. The 4-bit layout adds a 15-second weight and has three fixed minute-based codes. In both layouts an all-zero code means the transmission is not time-limited.

Top module: `tx_timeout_timer`

## Requirements
- R1: With CFG_W=3, cfg bit 2 adds 120 s, bit 1 adds 60 s and bit 0 adds 30 s. `expired` rises, and `tx_allow` falls, right after the clock edge that samples the limit-th tick of a press.
- R2: With CFG_W=3 and cfg=3'b111, `tx_inhibit` is 1 and `tx_allow` is 0 whatever the state of `ptt` and `tick_1hz`.
- R3: A cfg of all zeros gives no time-out: `expired` never rises during a press, however many ticks arrive.
- R4: `tx_allow` is 1 exactly when `ptt` is held, the press has been registered on a clock edge, the time-out has not expired and the channel is not inhibited. It is 0 whenever `ptt` is 0.
- R5: The limit and the cfg value are captured on the first clock edge at which `ptt` is seen high. A tick present on that same edge is not counted.
- R6: Every new press reloads the full limit, whatever time was used up by earlier presses.
- R7: After expiry, `expired` stays 1 and `tx_allow` stays 0 while `ptt` remains high, and further ticks change nothing. The first clock edge with `ptt` low clears `expired`.
- R8: With CFG_W=4, the weights are 120 s, 60 s, 30 s and 15 s (bits 3 to 0). Codes 4'b1011, 4'b0111 and 4'b0011 give 180 s, 120 s and 60 s respectively. Code 4'b0000 gives no time-out, and no code inhibits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| ptt | input | 1 | Push-to-talk request |
| cfg | input | CFG_W | Time-out weight code |
| tx_allow | output | 1 | Transmitter may key |
| expired | output | 1 | Time-out has run out for the current press |
| tx_inhibit | output | 1 | Channel code forbids transmit |

## Verification
If the down-counter loaded the wrong value or skipped a decrement, the fault shows as `expired` rising one or more ticks early or late. Every legal code is swept against the limit computed in the bench, so an error of a single tick in any weight or fixed code is seen on the tick where it happens. If the press-detect or release state were wrong, `expired` would fail to clear on the first cycle after `ptt` drops, or a second press would keep the leftover count. Both show up within one tick of the next expiry.

// File: rtl/tot_pkg.sv
package tot_pkg;

    localparam int SECS_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TIMED   = 2'd1,
        ST_FREE    = 2'd2,
        ST_EXPIRED = 2'd3
    } tot_state_e;

    typedef struct packed {
        logic              inhibit;
        logic              unlimited;
        logic [SECS_W-1:0] secs;
    } tot_limit_t;

    function automatic tot_limit_t decode_w3(input logic [2:0] c);
        tot_limit_t r;
        r.inhibit   = &c;
        r.unlimited = (c == 3'b000) || (&c);
        r.secs      = (c[2] ? SECS_W'(120) : SECS_W'(0))
                    + (c[1] ? SECS_W'(60)  : SECS_W'(0))
                    + (c[0] ? SECS_W'(30)  : SECS_W'(0));
        return r;
    endfunction

    function automatic tot_limit_t decode_w4(input logic [3:0] c);
        tot_limit_t r;
        r.inhibit   = 1'b0;
        r.unlimited = (c == 4'b0000);
        case (c)
            4'b1011: r.secs = SECS_W'(180);
            4'b0111: r.secs = SECS_W'(120);
            4'b0011: r.secs = SECS_W'(60);
            default: r.secs = (c[3] ? SECS_W'(120) : SECS_W'(0))
                            + (c[2] ? SECS_W'(60)  : SECS_W'(0))
                            + (c[1] ? SECS_W'(30)  : SECS_W'(0))
                            + (c[0] ? SECS_W'(15)  : SECS_W'(0));
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tot_cfg_decode.sv
module tot_cfg_decode #(
    parameter int CFG_W = 3
) (
    input  logic [CFG_W-1:0]  cfg,
    output tot_pkg::tot_limit_t lim
);
    generate
        if (CFG_W == 4) begin : g_w4
            assign lim = tot_pkg::decode_w4(cfg[3:0]);
        end else begin : g_w3
            assign lim = tot_pkg::decode_w3(cfg[2:0]);
        end
    endgenerate
endmodule

// File: rtl/tot_countdown.sv
module tot_countdown #(
    parameter int CNT_W = tot_pkg::SECS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    assign last = run && tick && (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && tick && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/tot_ptt_ctrl.sv
module tot_ptt_ctrl (
    input  logic                clk,
    input  logic                rst,
    input  logic                ptt,
    input  logic                unlimited,
    input  logic                last,
    output logic                load,
    output logic                run,
    output tot_pkg::tot_state_e state
);
    import tot_pkg::*;

    tot_state_e nxt;

    assign load = (state == ST_IDLE) && ptt;
    assign run  = (state == ST_TIMED);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (ptt) nxt = unlimited ? ST_FREE : ST_TIMED;
            ST_TIMED:   if (!ptt) nxt = ST_IDLE;
                        else if (last) nxt = ST_EXPIRED;
            ST_FREE:    if (!ptt) nxt = ST_IDLE;
            ST_EXPIRED: if (!ptt) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/tx_timeout_timer.sv
module tx_timeout_timer #(
    parameter int CFG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_1hz,
    input  logic             ptt,
    input  logic [CFG_W-1:0] cfg,
    output logic             tx_allow,
    output logic             expired,
    output logic             tx_inhibit
);
    import tot_pkg::*;

    localparam int CNT_W = SECS_W;

    tot_limit_t lim;
    tot_state_e state;
    logic       load;
    logic       run;
    logic       last;

    tot_cfg_decode #(.CFG_W(CFG_W)) u_dec (
        .cfg (cfg),
        .lim (lim)
    );

    tot_ptt_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ptt       (ptt),
        .unlimited (lim.unlimited),
        .last      (last),
        .load      (load),
        .run       (run),
        .state     (state)
    );

    tot_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (lim.secs),
        .run      (run),
        .tick     (tick_1hz),
        .last     (last)
    );

    assign tx_inhibit = lim.inhibit;
    assign expired    = (state == ST_EXPIRED);
    assign tx_allow   = ptt && !lim.inhibit
                      && ((state == ST_TIMED) || (state == ST_FREE));
endmodule

// File: rtl/tot_checker.sv
module tot_checker #(
    parameter int CFG_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_1hz,
    input logic             ptt,
    input logic [CFG_W-1:0] cfg,
    input logic             tx_allow,
    input logic             expired,
    input logic             tx_inhibit
);
    assert_inhibit_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        tx_inhibit |-> !tx_allow);

    assert_no_ptt_no_tx_R4: assert property (@(posedge clk) disable iff (rst)
        !ptt |-> !tx_allow);

    assert_expired_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        expired |-> !tx_allow);

    assert_expired_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (expired && ptt) |=> expired);

    assert_release_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !ptt |=> !expired);

    assert_fresh_press_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ptt) |=> !expired);
endmodule

bind tx_timeout_timer tot_checker #(.CFG_W(CFG_W)) u_tot_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_1hz   (tick_1hz),
    .ptt        (ptt),
    .cfg        (cfg),
    .tx_allow   (tx_allow),
    .expired    (expired),
    .tx_inhibit (tx_inhibit)
);

// File: tb/test_tx_timeout_timer.sv
module test_tx_timeout_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       ptt3 = 1'b0;
    logic       ptt4 = 1'b0;
    logic [2:0] cfg3 = '0;
    logic [3:0] cfg4 = '0;
    logic       allow3, exp3, inh3, allow4, exp4, inh4;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    tx_timeout_timer #(.CFG_W(3)) i_tx_timeout_timer (
        .clk(clk), .rst(rst), .tick_1hz(tick), .ptt(ptt3), .cfg(cfg3),
        .tx_allow(allow3), .expired(exp3), .tx_inhibit(inh3));

    tx_timeout_timer #(.CFG_W(4)) i_tx_timeout_timer_w4 (
        .clk(clk), .rst(rst), .tick_1hz(tick), .ptt(ptt4), .cfg(cfg4),
        .tx_allow(allow4), .expired(exp4), .tx_inhibit(inh4));

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lim3(input int c);
        return 120 * ((c >> 2) & 1) + 60 * ((c >> 1) & 1) + 30 * (c & 1);
    endfunction

    function automatic int lim4(input int c);
        if (c == 11) return 180;
        if (c == 7)  return 120;
        if (c == 3)  return 60;
        return 120 * ((c >> 3) & 1) + 60 * ((c >> 2) & 1)
             + 30 * ((c >> 1) & 1) + 15 * (c & 1);
    endfunction

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_ptt(input bit w4, input bit v);
        if (w4) ptt4 = v; else ptt3 = v;
        @(negedge clk);
    endtask

    task automatic run_limit(input bit w4, input int code, input string req);
        int lim;
        lim = w4 ? lim4(code) : lim3(code);
        if (w4) cfg4 = 4'(code); else cfg3 = 3'(code);
        set_ptt(w4, 1'b1);
        check({req, " allowed after press"}, w4 ? allow4 : allow3, 1);
        ticks(lim - 1);
        check({req, " still allowed one tick before limit"}, w4 ? allow4 : allow3, 1);
        check({req, " not expired one tick before limit"}, w4 ? exp4 : exp3, 0);
        ticks(1);
        check({req, " expired at limit"}, w4 ? exp4 : exp3, 1);
        check({req, " tx blocked at limit"}, w4 ? allow4 : allow3, 0);
        ticks(2);
        check("R7 expired holds while ptt high", w4 ? exp4 : exp3, 1);
        set_ptt(w4, 1'b0);
        check("R7 release clears expired", w4 ? exp4 : exp3, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R4 reset allow", allow3, 0);
        check("R4 reset expired", exp3, 0);
        check("R4 reset allow w4", allow4, 0);

        // R1: sweep every timed 3-bit code
        for (int c = 1; c < 7; c++) run_limit(1'b0, c, "R1");
        // R8: sweep every timed 4-bit code
        for (int c = 1; c < 16; c++) run_limit(1'b1, c, "R8");
        check("R8 no inhibit code in 4-bit layout", inh4, 0);

        // R3: zero code never expires
        cfg3 = 3'b000;
        set_ptt(1'b0, 1'b1);
        ticks(300);
        check("R3 zero code 3-bit not expired", exp3, 0);
        check("R3 zero code 3-bit allowed", allow3, 1);
        set_ptt(1'b0, 1'b0);
        check("R4 allow low after release", allow3, 0);
        cfg4 = 4'b0000;
        set_ptt(1'b1, 1'b1);
        ticks(300);
        check("R8 zero code 4-bit not expired", exp4, 0);
        check("R8 zero code 4-bit allowed", allow4, 1);
        set_ptt(1'b1, 1'b0);

        // R2: inhibit code
        cfg3 = 3'b111;
        @(negedge clk);
        check("R2 inhibit flag", inh3, 1);
        set_ptt(1'b0, 1'b1);
        ticks(5);
        check("R2 inhibit blocks tx", allow3, 0);
        check("R2 inhibit flag with ptt", inh3, 1);
        set_ptt(1'b0, 1'b0);
        cfg3 = 3'b001;
        @(negedge clk);
        check("R2 inhibit clears on other code", inh3, 0);

        // R5: tick on the press edge is ignored
        ptt3 = 1'b1;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        ticks(29);
        check("R5 edge tick not counted", exp3, 0);
        ticks(1);
        check("R5 expires after 30 further ticks", exp3, 1);
        set_ptt(1'b0, 1'b0);

        // R5: cfg change during a press does not alter the limit
        cfg3 = 3'b001;
        set_ptt(1'b0, 1'b1);
        cfg3 = 3'b100;
        ticks(30);
        check("R5 limit captured at press", exp3, 1);
        set_ptt(1'b0, 1'b0);
        cfg3 = 3'b001;

        // R6: a new press reloads the full limit
        set_ptt(1'b0, 1'b1);
        ticks(20);
        set_ptt(1'b0, 1'b0);
        ticks(3);
        set_ptt(1'b0, 1'b1);
        ticks(29);
        check("R6 reload after partial use", allow3, 1);
        ticks(1);
        check("R6 full limit then expiry", exp3, 1);
        set_ptt(1'b0, 1'b0);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule